// File: doc/BRIEF.md
# Master clock source selector and divider

This block derives two clock-enable streams, one for the processor and one for the master bus, from a choice of three time bases: the slow oscillator, the main oscillator and the PLL A output. Every time base arrives as a single-cycle enable pulse on one fast system clock, so the block and everything downstream of it stay fully synchronous. The enables are used to gate logic that would otherwise run on a derived clock.

Software writes one configuration word that holds the source select, a power-of-two prescaler, a master divider and a halving option for the PLL path. A new word is held pending and only replaces the active one at the end of a master-clock period, so no shortened period is produced. A ready flag reports when a new source or prescaler has settled, and it also drops while the selected PLL has lost lock. During that time the main oscillator stands in for the PLL. The ready flag can be polled, or it can drive a level interrupt when enabled.

Top module: `mclk_gen`

## Requirements
- R1: With source select field value 1 (main), the processor enable fires once every 2^P source pulses, where P is the 3-bit prescaler field for values 0 to 6; value 7 divides by 64.
- R2: The master enable fires on every Nth processor enable, with N = 1, 2, 4 and 3 for divider field values 0, 1, 2 and 3; every master enable coincides with a processor enable.
- R3: With the source select field at 2 (PLL A) and lock high, the PLL pulses are used directly when the halving bit is 0 and every second PLL pulse is used when it is 1.
- R4: Source select field value 0 picks the slow pulses and value 3 also picks the slow pulses.
- R5: After reset the active setting is main source, prescaler 0, divider 0, halving 0, and ready is 1, so both enables follow the main pulses one for one.
- R6: A written setting becomes active on the clock edge that ends the cycle of the next master enable; until then the old setting governs both enables.
- R7: A write whose source select or prescaler value differs from the last written value clears ready on the following cycle; a write that changes only the divider or halving bit leaves ready at 1.
- R8: After a setting that cleared ready becomes active, ready returns to 1 on the cycle after the fourth master enable that follows the switching enable, so five master enables are seen while ready is low.
- R9: While the active source is PLL A and lock is low, the main pulses drive the dividers and ready is 0 from the next cycle; after lock returns, ready sets on the cycle after the fourth master enable.
- R10: The interrupt output equals ready AND the interrupt-enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| slow_tick | input | 1 | One-cycle pulse per slow oscillator period |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| pll_tick | input | 1 | One-cycle pulse per PLL A period |
| pll_lock | input | 1 | PLL A lock indication, high when locked |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_css | input | 2 | Source select: 0 slow, 1 main, 2 PLL A, 3 slow |
| cfg_pres | input | 3 | Prescaler exponent, 7 treated as 6 |
| cfg_mdiv | input | 2 | Master divider code: 0 /1, 1 /2, 2 /4, 3 /3 |
| cfg_pll_half | input | 1 | Halve the PLL A pulse rate before selection |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| pck_en | output | 1 | Processor clock enable |
| mck_en | output | 1 | Master clock enable |
| ready | output | 1 | Setting settled and source valid |
| irq | output | 1 | Level interrupt, ready gated by irq_en |

## Verification
The assertions take the source inputs to be one-cycle pulses on the system clock, the write strobe to be a single-cycle pulse with the fields valid in the same cycle, and the lock input to change only between clock edges; under those conditions the counters never pass their limits and ready only rises on a master enable. The stimulus keeps to this by generating each source from a fixed-ratio counter on the bench clock, holding the write strobe for exactly one cycle, and moving lock at the same point after the edge as all other inputs. A behavioural model of the divide chain and ready sequencing is stepped alongside the design, and targeted measurements of enable spacing cover every prescaler and divider code, both halving settings, the slow and reserved selects, and a lock loss with recovery.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

  typedef enum logic [1:0] {
    SRC_SLOW     = 2'd0,
    SRC_MAIN     = 2'd1,
    SRC_PLL      = 2'd2,
    SRC_ALT_SLOW = 2'd3
  } src_e;

  typedef struct packed {
    src_e       css;
    logic [2:0] pres;
    logic [1:0] mdiv;
    logic       pll_half;
  } mclk_cfg_t;

  localparam mclk_cfg_t CFG_RESET = '{
    css:      SRC_MAIN,
    pres:     3'd0,
    mdiv:     2'd0,
    pll_half: 1'b0
  };

endpackage

// File: rtl/mclk_src_sel.sv
module mclk_src_sel
  import mclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_e sel_css,
  input  logic pll_half,
  input  logic slow_tick,
  input  logic main_tick,
  input  logic pll_tick,
  input  logic pll_lock,
  output logic src_tick,
  output logic pll_lost
);

  logic half_q;
  logic half_d;
  logic pll_eff;
  src_e eff_css;

  // toggle on every PLL pulse; used to pick every second one
  always_comb begin
    half_d = pll_tick ? ~half_q : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  always_comb begin
    pll_lost = (sel_css == SRC_PLL) && !pll_lock;
    eff_css  = pll_lost ? SRC_MAIN : sel_css;
    pll_eff  = pll_half ? (pll_tick & half_q) : pll_tick;
    case (eff_css)
      SRC_MAIN: src_tick = main_tick;
      SRC_PLL:  src_tick = pll_eff;
      default:  src_tick = slow_tick;
    endcase
  end

endmodule

// File: rtl/mclk_divider.sv
module mclk_divider #(
  parameter int MAX_EXP = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic [2:0] pres,
  input  logic [1:0] mdiv,
  output logic       pck_en,
  output logic       mck_en
);

  localparam int CW = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [CW-1:0] pre_q, pre_d, pre_lim;
  logic [1:0]    md_q, md_d, md_lim;
  logic [2:0]    exp_sel;

  always_comb begin
    exp_sel = (int'(pres) > MAX_EXP) ? 3'(MAX_EXP) : pres;
    pre_lim = CW'((64'd1 << exp_sel) - 64'd1);
    case (mdiv)
      2'd0:    md_lim = 2'd0;
      2'd1:    md_lim = 2'd1;
      2'd2:    md_lim = 2'd3;
      default: md_lim = 2'd2;
    endcase
    pck_en = src_tick && (pre_q == pre_lim);
    mck_en = pck_en && (md_q == md_lim);
  end

  always_comb begin
    pre_d = pre_q;
    if (src_tick) pre_d = (pre_q == pre_lim) ? '0 : pre_q + 1'b1;
    md_d = md_q;
    if (pck_en) md_d = (md_q == md_lim) ? 2'd0 : md_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      md_q  <= 2'd0;
    end else begin
      pre_q <= pre_d;
      md_q  <= md_d;
    end
  end

  // R1
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= pre_lim);

  // R2
  mdiv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    md_q <= md_lim);

endmodule

// File: rtl/mclk_ctrl.sv
module mclk_ctrl
  import mclk_pkg::*;
#(
  parameter int SETTLE_TICKS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  mclk_cfg_t cfg_wr,
  input  logic      mck_en,
  input  logic      pll_lost,
  output mclk_cfg_t act_cfg,
  output logic      ready
);

  localparam int SW = $clog2(SETTLE_TICKS + 1);

  mclk_cfg_t     pend_q, pend_d, act_q, act_d;
  logic          pv_q, pv_d;
  logic          rdy_q, rdy_d;
  logic          wait_q, wait_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          changed;
  logic          apply;

  always_comb begin
    changed = cfg_we && ((cfg_wr.css != pend_q.css) || (cfg_wr.pres != pend_q.pres));
    apply   = mck_en && pv_q;

    pend_d = cfg_we ? cfg_wr : pend_q;
    act_d  = apply ? pend_q : act_q;
    pv_d   = pv_q;
    if (apply)  pv_d = 1'b0;
    if (cfg_we) pv_d = 1'b1;

    rdy_d  = rdy_q;
    wait_d = wait_q;
    cnt_d  = cnt_q;
    if (!rdy_q && !wait_q && (cnt_q != '0) && mck_en) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == SW'(1)) rdy_d = 1'b1;
    end
    if (apply && wait_q) begin
      wait_d = 1'b0;
      cnt_d  = SW'(SETTLE_TICKS);
    end
    if (pll_lost) begin
      rdy_d = 1'b0;
      cnt_d = SW'(SETTLE_TICKS);
    end
    if (changed) begin
      rdy_d  = 1'b0;
      wait_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= CFG_RESET;
      act_q  <= CFG_RESET;
      pv_q   <= 1'b0;
      rdy_q  <= 1'b1;
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      pv_q   <= pv_d;
      rdy_q  <= rdy_d;
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

  assign act_cfg = act_q;
  assign ready   = rdy_q;

  // R7
  change_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> !rdy_q);

  // R9
  unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_lost |=> !rdy_q);

  // R8
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(mck_en));

  // R6
  switch_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(mck_en));

endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
  import mclk_pkg::*;
#(
  parameter int MAX_EXP      = 6,
  parameter int SETTLE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       main_tick,
  input  logic       pll_tick,
  input  logic       pll_lock,
  input  logic       cfg_we,
  input  logic [1:0] cfg_css,
  input  logic [2:0] cfg_pres,
  input  logic [1:0] cfg_mdiv,
  input  logic       cfg_pll_half,
  input  logic       irq_en,
  output logic       pck_en,
  output logic       mck_en,
  output logic       ready,
  output logic       irq
);

  logic [1:0] rs_q;
  logic       rst_int_n;
  mclk_cfg_t  cfg_wr;
  mclk_cfg_t  act_cfg;
  logic       src_tick;
  logic       pll_lost;

  // asynchronous assertion, release after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    cfg_wr.css      = src_e'(cfg_css);
    cfg_wr.pres     = cfg_pres;
    cfg_wr.mdiv     = cfg_mdiv;
    cfg_wr.pll_half = cfg_pll_half;
  end

  mclk_src_sel u_src (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_css   (act_cfg.css),
    .pll_half  (act_cfg.pll_half),
    .slow_tick (slow_tick),
    .main_tick (main_tick),
    .pll_tick  (pll_tick),
    .pll_lock  (pll_lock),
    .src_tick  (src_tick),
    .pll_lost  (pll_lost)
  );

  mclk_divider #(.MAX_EXP(MAX_EXP)) u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src_tick (src_tick),
    .pres     (act_cfg.pres),
    .mdiv     (act_cfg.mdiv),
    .pck_en   (pck_en),
    .mck_en   (mck_en)
  );

  mclk_ctrl #(.SETTLE_TICKS(SETTLE_TICKS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_we   (cfg_we),
    .cfg_wr   (cfg_wr),
    .mck_en   (mck_en),
    .pll_lost (pll_lost),
    .act_cfg  (act_cfg),
    .ready    (ready)
  );

  assign irq = ready & irq_en;

endmodule

// File: tb/mclk_gen_test.sv
`timescale 1ns/1ps
module mclk_gen_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0, main_tick = 1'b0, pll_tick = 1'b0;
  logic pll_lock = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_css = 2'd1;
  logic [2:0] cfg_pres = 3'd0;
  logic [1:0] cfg_mdiv = 2'd0;
  logic cfg_pll_half = 1'b0;
  logic irq_en = 1'b0;
  logic pck_en, mck_en, ready, irq;

  int n_tests = 0;
  int n_fail = 0;
  bit tick_run = 0;
  bit pll_run = 0;
  bit model_on = 0;
  bit done = 0;
  int tcyc = 0;
  string phase = "R5";

  always #2 clk = ~clk;

  mclk_gen uut (
    .clk(clk), .rst_n(rst_n),
    .slow_tick(slow_tick), .main_tick(main_tick), .pll_tick(pll_tick),
    .pll_lock(pll_lock), .cfg_we(cfg_we), .cfg_css(cfg_css),
    .cfg_pres(cfg_pres), .cfg_mdiv(cfg_mdiv), .cfg_pll_half(cfg_pll_half),
    .irq_en(irq_en), .pck_en(pck_en), .mck_en(mck_en),
    .ready(ready), .irq(irq)
  );

  // source pulse generators: main every 3 cycles, slow every 11, PLL every cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      tcyc++;
      main_tick = tick_run && (tcyc % 3 == 0);
      slow_tick = tick_run && (tcyc % 11 == 0);
      pll_tick  = tick_run && pll_run;
    end
  end

  // behavioural reference model
  int a_css = 1, a_pres = 0, a_mdiv = 0, a_ph = 0;
  int p_css = 1, p_pres = 0, p_mdiv = 0, p_ph = 0;
  int m_pv = 0, m_rdy = 1, m_wait = 0, m_cnt = 0;
  int m_half = 0, m_pre = 0, m_md = 0;
  int lost, eff, pe, st, ex, plim, dlim, xp, xm, ap, chg, nr, nw, nc, xi;

  always @(negedge clk) begin
    if (model_on && !done) begin
      lost = (a_css == 2 && !pll_lock) ? 1 : 0;
      eff  = lost ? 1 : a_css;
      pe   = a_ph ? int'(pll_tick && m_half != 0) : int'(pll_tick);
      st   = (eff == 1) ? int'(main_tick) : (eff == 2) ? pe : int'(slow_tick);
      ex   = (a_pres > 6) ? 6 : a_pres;
      plim = (1 << ex) - 1;
      dlim = (a_mdiv == 0) ? 0 : (a_mdiv == 1) ? 1 : (a_mdiv == 2) ? 3 : 2;
      xp   = (st != 0 && m_pre == plim) ? 1 : 0;
      xm   = (xp != 0 && m_md == dlim) ? 1 : 0;
      xi   = (m_rdy != 0 && irq_en) ? 1 : 0;
      n_tests++;
      if (int'(pck_en) != xp || int'(mck_en) != xm || int'(ready) != m_rdy || int'(irq) != xi) begin
        n_fail++;
        $display("FAIL %s per-cycle model: pck_en %0b/%0d mck_en %0b/%0d ready %0b/%0d irq %0b/%0d (actual/expected)",
                 phase, pck_en, xp, mck_en, xm, ready, m_rdy, irq, xi);
      end
      if (pll_tick) m_half = 1 - m_half;
      if (st != 0) m_pre = (m_pre == plim) ? 0 : m_pre + 1;
      if (xp != 0) m_md = (m_md == dlim) ? 0 : m_md + 1;
      ap  = (xm != 0 && m_pv != 0) ? 1 : 0;
      chg = (cfg_we && (int'(cfg_css) != p_css || int'(cfg_pres) != p_pres)) ? 1 : 0;
      nr = m_rdy; nw = m_wait; nc = m_cnt;
      if (m_rdy == 0 && m_wait == 0 && m_cnt > 0 && xm != 0) begin
        nc = m_cnt - 1;
        if (m_cnt == 1) nr = 1;
      end
      if (ap != 0 && m_wait != 0) begin nw = 0; nc = 4; end
      if (lost != 0) begin nr = 0; nc = 4; end
      if (chg != 0) begin nr = 0; nw = 1; end
      if (ap != 0) begin
        a_css = p_css; a_pres = p_pres; a_mdiv = p_mdiv; a_ph = p_ph;
        m_pv = 0;
      end
      if (cfg_we) begin
        p_css = int'(cfg_css); p_pres = int'(cfg_pres);
        p_mdiv = int'(cfg_mdiv); p_ph = int'(cfg_pll_half);
        m_pv = 1;
      end
      m_rdy = nr; m_wait = nw; m_cnt = nc;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int css, input int pres, input int mdiv, input int ph);
    @(posedge clk);
    #1;
    cfg_we = 1'b1;
    cfg_css = 2'(css); cfg_pres = 3'(pres); cfg_mdiv = 2'(mdiv); cfg_pll_half = 1'(ph);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic next_pulse(input bit use_m);
    do @(negedge clk); while (!(use_m ? mck_en : pck_en));
  endtask

  task automatic apply_wait();
    next_pulse(1'b1);
    while (!ready) @(negedge clk);
  endtask

  task automatic gap(input bit use_m, output int g);
    time t0;
    next_pulse(use_m);
    next_pulse(use_m);
    t0 = $time;
    next_pulse(use_m);
    g = int'(($time - t0) / 4);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL %s watchdog: actual 200000 cycles elapsed, expected completion", phase);
      report();
      $finish;
    end
  end

  initial begin
    int g, cnt, base;
    int fac[4] = '{1, 2, 4, 3};
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    model_on = 1;
    tick_run = 1;
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R5", "ready after reset", int'(ready), 1);
    chk("R10", "irq with enable low", int'(irq), 0);
    gap(1'b0, g); chk("R5", "reset pck spacing", g, 3);
    gap(1'b1, g); chk("R5", "reset mck spacing", g, 3);

    @(posedge clk); #1 irq_en = 1'b1;
    @(negedge clk);
    chk("R10", "irq with enable high and ready", int'(irq), 1);

    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 4; d++) begin
        phase = "R1";
        wr(1, p, d, 0);
        @(negedge clk);
        chk("R7", "ready after write", int'(ready), (d == 0 && p > 0) ? 0 : 1);
        apply_wait();
        base = 3 * (1 << ((p > 6) ? 6 : p));
        gap(1'b0, g); chk("R1", "pck spacing", g, base);
        phase = "R2";
        gap(1'b1, g); chk("R2", "mck spacing", g, base * fac[d]);
      end
    end

    phase = "R8";
    wr(1, 2, 0, 0);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      if (mck_en) cnt++;
    end
    chk("R8", "master enables while not ready", cnt, 5);
    phase = "R6";
    gap(1'b1, g); chk("R6", "mck spacing after switch", g, 12);

    phase = "R4";
    wr(0, 0, 0, 0);
    apply_wait();
    gap(1'b0, g); chk("R4", "slow source spacing", g, 11);
    wr(3, 0, 0, 0);
    apply_wait();
    gap(1'b0, g); chk("R4", "reserved select spacing", g, 11);

    phase = "R3";
    @(posedge clk); #1 pll_run = 1;
    wr(2, 0, 0, 0);
    apply_wait();
    gap(1'b0, g); chk("R3", "PLL direct spacing", g, 1);
    wr(2, 0, 0, 1);
    @(negedge clk);
    chk("R7", "ready after halving-only write", int'(ready), 1);
    apply_wait();
    gap(1'b0, g); chk("R3", "PLL halved pck spacing", g, 2);
    gap(1'b1, g); chk("R3", "PLL halved mck spacing", g, 2);

    phase = "R9";
    @(posedge clk); #1 pll_lock = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "ready after lock loss", int'(ready), 0);
    chk("R10", "irq while not ready", int'(irq), 0);
    gap(1'b0, g); chk("R9", "fallback spacing", g, 3);
    @(posedge clk); #1 pll_lock = 1'b1;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      if (mck_en) cnt++;
    end
    chk("R9", "master enables before ready after relock", cnt, 4);
    gap(1'b0, g); chk("R9", "PLL spacing after relock", g, 2);

    phase = "R10";
    @(posedge clk); #1 irq_en = 1'b0;
    @(negedge clk);
    chk("R10", "irq after enable cleared", int'(irq), 0);
    chk("R10", "ready held", int'(ready), 1);

    if (!done) begin
      done = 1;
      report();
      $finish;
    end
  end

endmodule